// File: doc/BRIEF.md
# Streaming Vector Length Control Register

This block is a 64-bit control register for the highest privilege level, used while a processor runs in its streaming vector mode. It receives an already decoded system-register access (read or write), together with the privilege level of the requester and an external enable. From these it decides whether the access is undefined, trapped or performed. Reserved bits are not stored and always read as zero.

The stored length field asks for a streaming vector length of (field+1)*128 bits. A resolver turns that request into an effective length. The legal lengths are the powers of two from 128 to 2048 bits, and a parameter mask chooses which of them the implementation supports. A request below the smallest supported length resolves to that smallest length. Any other request resolves to the largest supported length that does not exceed it. A direct read still returns the raw field.

A second control bit gates instructions that touch the lookup-table register. When they are gated, the block raises a trap decision with its class and syndrome. That decision is suppressed whenever a trap caused by the streaming-mode bit or the array-enable bit is already pending.

Top module: `streaming_vl_ctrl`

## Requirements
- R1: After synchronous reset, every writable field is 0: a permitted read returns 0, `full_isa_en` is 0, and the effective length equals the resolver result for a field value of 0.
- R2: Only bit 31 (full-instruction-set enable), bit 30 (lookup-table access enable, 1 = allowed) and bits 3:0 (length field) are stored. Every other bit reads as 0 and ignores writes.
- R3: An access with `acc_level` 0, 1 or 2 returns `resp_undef`=1, `resp_trap`=0, read data 0, and leaves the register unchanged.
- R4: An access at level 3 with `acc_enable`=0 returns `resp_trap`=1 with `resp_class`=0x1D and read data 0, and leaves the register unchanged.
- R5: A permitted read returns the stored length field unchanged, not the resolved length.
- R6: `eff_vl_bits` is the largest supported length (bit i of `SUPPORTED_MASK` = 128<<i bits) that does not exceed the request.
- R7: When the request is smaller than every supported length, `eff_vl_bits` is the smallest supported length.
- R8: Each access response (`resp_valid` and its fields) appears exactly one cycle after `acc_valid`. A permitted write is visible on `eff_vl_bits`, `req_vl_bits` and `full_isa_en` in that same following cycle.
- R9: With bit 30 stored as 0, `lut_insn`=1 gives `lut_trap`=1 in the same cycle, with `lut_trap_class`=0x1D and `lut_trap_iss`=0x0000004. With bit 30 stored as 1, `lut_trap` stays 0.
- R10: `lut_trap` is 0 whenever `sm_trap_pending` or `za_trap_pending` is 1.
- R11: `req_vl_bits` equals (length field + 1) * 128.
- R12: `full_isa_en` follows stored bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Decoded register access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_level | input | 2 | Privilege level of the requester |
| acc_enable | input | 1 | External access enable for level 3 |
| acc_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Access response valid |
| resp_undef | output | 1 | Access was undefined |
| resp_trap | output | 1 | Access was trapped |
| resp_class | output | 6 | Exception class of a trapped access |
| resp_rdata | output | 64 | Read data (0 unless a permitted read) |
| lut_insn | input | 1 | An instruction touching the lookup-table register is issued |
| sm_trap_pending | input | 1 | Higher-priority streaming-mode trap pending |
| za_trap_pending | input | 1 | Higher-priority array-enable trap pending |
| lut_trap | output | 1 | Lookup-table access trap |
| lut_trap_class | output | 6 | Exception class of the lookup-table trap |
| lut_trap_iss | output | 25 | Syndrome of the lookup-table trap |
| full_isa_en | output | 1 | Stored full-instruction-set enable |
| req_vl_bits | output | 12 | Requested length in bits |
| eff_vl_bits | output | 12 | Effective streaming length in bits |

## Verification
Access responses are registered. The bench drives each access on a falling edge and queues the expected response. A monitor then compares it on the following falling edge, after the one rising edge at which `resp_valid` rises. The length outputs and `full_isa_en` come straight from the stored fields, so the bench samples them on the falling edge that ends a write, one rising edge after it was issued. The lookup-table trap is combinational and is sampled 1 ns after its inputs change, within the same cycle.

// File: rtl/svl_pkg.sv
package svl_pkg;
    localparam int WORD_W      = 64;
    localparam int LEN_W       = 4;
    localparam int NUM_SIZES   = 5;
    localparam int VL_W        = 12;
    localparam int UNIT_SHIFT  = 7;
    localparam int CLASS_W     = 6;
    localparam int ISS_W       = 25;
    localparam int FULLISA_BIT = 31;
    localparam int LUTEN_BIT   = 30;
    localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h1D;
    localparam logic [ISS_W-1:0]   LUT_ISS    = 25'h0000004;
    localparam logic [1:0]         LVL_TOP    = 2'd3;
    localparam logic [WORD_W-1:0]  KEEP_MASK  =
        (64'd1 << FULLISA_BIT) | (64'd1 << LUTEN_BIT) | 64'((1 << LEN_W) - 1);

    typedef struct packed {
        logic             full_isa;
        logic             lut_en;
        logic [LEN_W-1:0] len;
    } ctrl_fields_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_OK    = 2'd1,
        ACC_UNDEF = 2'd2,
        ACC_TRAP  = 2'd3
    } acc_verdict_e;

    function automatic logic [WORD_W-1:0] pack_fields(input ctrl_fields_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FULLISA_BIT] = f.full_isa;
        w[LUTEN_BIT]   = f.lut_en;
        w[LEN_W-1:0]   = f.len;
        return w;
    endfunction

    function automatic ctrl_fields_t unpack_fields(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.full_isa = w[FULLISA_BIT];
        f.lut_en   = w[LUTEN_BIT];
        f.len      = w[LEN_W-1:0];
        return f;
    endfunction

    function automatic int lowest_set(input logic [NUM_SIZES-1:0] m);
        int idx;
        idx = 0;
        for (int i = NUM_SIZES - 1; i >= 0; i--) begin
            if (m[i]) idx = i;
        end
        return idx;
    endfunction
endpackage

// File: rtl/svl_access_gate.sv
module svl_access_gate
    import svl_pkg::*;
(
    input  logic         acc_valid,
    input  logic [1:0]   acc_level,
    input  logic         acc_enable,
    output acc_verdict_e verdict
);
    always_comb begin
        if (!acc_valid)              verdict = ACC_NONE;
        else if (acc_level != LVL_TOP) verdict = ACC_UNDEF;
        else if (!acc_enable)        verdict = ACC_TRAP;
        else                         verdict = ACC_OK;
    end
endmodule

// File: rtl/svl_field_reg.sv
module svl_field_reg
    import svl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output ctrl_fields_t      fields
);
    logic [WORD_W-1:0] kept;

    assign kept = wr_word & KEEP_MASK;

    always_ff @(posedge clk) begin
        if (rst)        fields <= '0;
        else if (wr_en) fields <= unpack_fields(kept);
    end
endmodule

// File: rtl/svl_len_resolve.sv
module svl_len_resolve
    import svl_pkg::*;
#(
    parameter logic [NUM_SIZES-1:0] SUPPORTED_MASK = 5'b10110
) (
    input  logic [LEN_W-1:0] len,
    output logic [VL_W-1:0]  req_bits,
    output logic [VL_W-1:0]  eff_bits
);
    localparam int MIN_IDX = lowest_set(SUPPORTED_MASK);
    localparam int UNITS_W = LEN_W + 1;

    logic [UNITS_W-1:0] req_units;
    logic [2:0]         pick;

    assign req_units = UNITS_W'(len) + UNITS_W'(1);
    assign req_bits  = VL_W'({req_units, {UNIT_SHIFT{1'b0}}});

    // ascending scan: the last qualifying size is the largest one
    always_comb begin
        pick = 3'(MIN_IDX);
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (SUPPORTED_MASK[i] && ((UNITS_W'(1) << i) <= req_units))
                pick = 3'(i);
        end
    end

    assign eff_bits = VL_W'(1 << UNIT_SHIFT) << pick;
endmodule

// File: rtl/streaming_vl_ctrl.sv
module streaming_vl_ctrl
    import svl_pkg::*;
#(
    parameter logic [NUM_SIZES-1:0] SUPPORTED_MASK = 5'b10110
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_level,
    input  logic              acc_enable,
    input  logic [WORD_W-1:0] acc_wdata,
    output logic              resp_valid,
    output logic              resp_undef,
    output logic              resp_trap,
    output logic [CLASS_W-1:0] resp_class,
    output logic [WORD_W-1:0] resp_rdata,
    input  logic              lut_insn,
    input  logic              sm_trap_pending,
    input  logic              za_trap_pending,
    output logic              lut_trap,
    output logic [CLASS_W-1:0] lut_trap_class,
    output logic [ISS_W-1:0]  lut_trap_iss,
    output logic              full_isa_en,
    output logic [VL_W-1:0]   req_vl_bits,
    output logic [VL_W-1:0]   eff_vl_bits
);
    localparam int MIN_VL = (1 << UNIT_SHIFT) << lowest_set(SUPPORTED_MASK);

    acc_verdict_e verdict;
    ctrl_fields_t fields;
    logic         wr_ok;

    svl_access_gate u_gate (
        .acc_valid  (acc_valid),
        .acc_level  (acc_level),
        .acc_enable (acc_enable),
        .verdict    (verdict)
    );

    assign wr_ok = (verdict == ACC_OK) && acc_write;

    svl_field_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_word (acc_wdata),
        .fields  (fields)
    );

    svl_len_resolve #(.SUPPORTED_MASK(SUPPORTED_MASK)) u_res (
        .len      (fields.len),
        .req_bits (req_vl_bits),
        .eff_bits (eff_vl_bits)
    );

    assign full_isa_en = fields.full_isa;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_undef <= 1'b0;
            resp_trap  <= 1'b0;
            resp_class <= '0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= verdict != ACC_NONE;
            resp_undef <= verdict == ACC_UNDEF;
            resp_trap  <= verdict == ACC_TRAP;
            resp_class <= (verdict == ACC_TRAP) ? TRAP_CLASS : '0;
            resp_rdata <= (verdict == ACC_OK && !acc_write) ? pack_fields(fields) : '0;
        end
    end

    // lookup-table trap ranks below pending mode/array traps
    always_comb begin
        lut_trap       = lut_insn && !fields.lut_en && !sm_trap_pending && !za_trap_pending;
        lut_trap_class = lut_trap ? TRAP_CLASS : '0;
        lut_trap_iss   = lut_trap ? LUT_ISS : '0;
    end

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> ((resp_rdata & ~KEEP_MASK) == '0));
    a_r3_undef_keeps: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_level != LVL_TOP) |=> ($stable(fields) && resp_undef));
    a_r4_trap_keeps: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_level == LVL_TOP && !acc_enable) |=> ($stable(fields) && resp_trap));
    a_r6_pow2_len: assert property (@(posedge clk) disable iff (rst)
        $countones(eff_vl_bits) == 1);
    a_r7_min_floor: assert property (@(posedge clk) disable iff (rst)
        eff_vl_bits >= VL_W'(MIN_VL));
    a_r8_write_seen: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_level == LVL_TOP && acc_enable)
        |=> (fields.len == $past(acc_wdata[LEN_W-1:0]) && resp_valid));
    a_r10_lut_rank: assert property (@(posedge clk) disable iff (rst)
        (sm_trap_pending || za_trap_pending) |-> !lut_trap);
endmodule

// File: tb/sim_streaming_vl_ctrl.sv
module sim_streaming_vl_ctrl;
    localparam logic [4:0] M0 = 5'b10110;
    localparam logic [4:0] M1 = 5'b01001;
    localparam logic [63:0] KEEP = 64'hC000_000F;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, acc_valid, acc_write, acc_enable, lut_insn, sm_p, za_p;
    logic [1:0] acc_level;
    logic [63:0] acc_wdata;
    logic rv0, ru0, rt0, lt0, fi0, rv1, ru1, rt1, lt1, fi1;
    logic [5:0] rc0, lc0, rc1, lc1;
    logic [63:0] rd0, rd1;
    logic [24:0] li0, li1;
    logic [11:0] rq0, ef0, rq1, ef1;

    streaming_vl_ctrl #(.SUPPORTED_MASK(M0)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_level(acc_level), .acc_enable(acc_enable), .acc_wdata(acc_wdata),
        .resp_valid(rv0), .resp_undef(ru0), .resp_trap(rt0), .resp_class(rc0),
        .resp_rdata(rd0), .lut_insn(lut_insn), .sm_trap_pending(sm_p),
        .za_trap_pending(za_p), .lut_trap(lt0), .lut_trap_class(lc0),
        .lut_trap_iss(li0), .full_isa_en(fi0), .req_vl_bits(rq0), .eff_vl_bits(ef0));

    streaming_vl_ctrl #(.SUPPORTED_MASK(M1)) u1 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_level(acc_level), .acc_enable(acc_enable), .acc_wdata(acc_wdata),
        .resp_valid(rv1), .resp_undef(ru1), .resp_trap(rt1), .resp_class(rc1),
        .resp_rdata(rd1), .lut_insn(lut_insn), .sm_trap_pending(sm_p),
        .za_trap_pending(za_p), .lut_trap(lt1), .lut_trap_class(lc1),
        .lut_trap_iss(li1), .full_isa_en(fi1), .req_vl_bits(rq1), .eff_vl_bits(ef1));

    typedef struct {
        string       req;
        logic        undef;
        logic        trap;
        logic [5:0]  cls;
        logic [63:0] rdata;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [63:0] model;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_eff(input logic [4:0] m, input int len);
        int best = -1, lo = -1;
        for (int i = 0; i < 5; i++) begin
            if (m[i]) begin
                if (lo < 0) lo = i;
                if ((1 << i) <= len + 1) best = i;
            end
        end
        if (best < 0) best = lo;
        return 128 << best;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic access(input string req, input logic wr, input logic [1:0] lvl,
                          input logic en, input logic [63:0] data);
        exp_t e;
        e.req = req; e.undef = 0; e.trap = 0; e.cls = 0; e.rdata = 0;
        if (lvl != 2'd3) e.undef = 1;
        else if (!en) begin e.trap = 1; e.cls = 6'h1D; end
        else if (wr) model = data & KEEP;
        else e.rdata = model;
        q.push_back(e);
        acc_valid = 1; acc_write = wr; acc_level = lvl; acc_enable = en; acc_wdata = data;
        @(negedge clk);
        acc_valid = 0; acc_write = 0; acc_wdata = 0;
    endtask

    // monitor: compare registered responses against queued expectations
    always @(negedge clk) begin
        if (!rst && rv0) begin
            if (q.size() == 0) chk("R8 unexpected response", 64'd1, 64'd0);
            else begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " undef"}, 64'(ru0), 64'(e.undef));
                chk({e.req, " trap"}, 64'(rt0), 64'(e.trap));
                chk({e.req, " class"}, 64'(rc0), 64'(e.cls));
                chk({e.req, " rdata"}, rd0, e.rdata);
            end
        end
    end

    initial begin
        #(20 * 100000);
        chk("watchdog", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        rst = 1; acc_valid = 0; acc_write = 0; acc_level = 0; acc_enable = 0;
        acc_wdata = 0; lut_insn = 0; sm_p = 0; za_p = 0; model = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state, R7 floor for len 0 on mask without 128
        chk("R1 full_isa", 64'(fi0), 64'd0);
        chk("R1 R7 eff u0", 64'(ef0), 64'(ref_eff(M0, 0)));
        chk("R1 eff u1", 64'(ef1), 64'(ref_eff(M1, 0)));
        access("R1 read after reset", 0, 2'd3, 1, 0);
        // R2 reserved masking
        access("R2 write ones", 1, 2'd3, 1, '1);
        access("R2 read masked", 0, 2'd3, 1, 0);
        chk("R12 full_isa set", 64'(fi0), 64'd1);
        // R6 R7 R11 R8 sweep
        for (int l = 0; l < 16; l++) begin
            access("R8 write len", 1, 2'd3, 1, 64'(l));
            chk($sformatf("R6 R7 eff u0 len=%0d", l), 64'(ef0), 64'(ref_eff(M0, l)));
            chk($sformatf("R6 R7 eff u1 len=%0d", l), 64'(ef1), 64'(ref_eff(M1, l)));
            chk($sformatf("R11 req len=%0d", l), 64'(rq0), 64'((l + 1) * 128));
            access("R5 raw read", 0, 2'd3, 1, 0);
        end
        chk("R12 full_isa clear", 64'(fi0), 64'd0);
        // R3 lower levels
        access("R8 write len5", 1, 2'd3, 1, 64'h5);
        for (int lv = 0; lv < 3; lv++) begin
            access("R3 undef write", 1, 2'(lv), 1, 64'hC000_000A);
            access("R3 undef read", 0, 2'(lv), 1, 0);
        end
        chk("R3 eff unchanged", 64'(ef0), 64'(ref_eff(M0, 5)));
        access("R3 read back", 0, 2'd3, 1, 0);
        // R4 enable gate
        access("R4 trap write", 1, 2'd3, 0, 64'hC000_000F);
        access("R4 trap read", 0, 2'd3, 0, 0);
        chk("R4 eff unchanged", 64'(ef0), 64'(ref_eff(M0, 5)));
        chk("R4 full_isa unchanged", 64'(fi0), 64'd0);
        access("R4 read back", 0, 2'd3, 1, 0);
        // R9 R10 lookup-table trap
        lut_insn = 1; #1;
        chk("R9 trap when bit30=0", 64'(lt0), 64'd1);
        chk("R9 class", 64'(lc0), 64'h1D);
        chk("R9 iss", 64'(li0), 64'h4);
        sm_p = 1; #1;
        chk("R10 sm pending", 64'(lt0), 64'd0);
        sm_p = 0; za_p = 1; #1;
        chk("R10 za pending", 64'(lt0), 64'd0);
        za_p = 0; lut_insn = 0;
        @(negedge clk);
        access("R9 allow lut", 1, 2'd3, 1, 64'h4000_0003);
        lut_insn = 1; #1;
        chk("R9 no trap when bit30=1", 64'(lt0), 64'd0);
        lut_insn = 0;
        repeat (3) @(negedge clk);
        chk("R8 queue drained", 64'(q.size()), 64'd0);
        finish_run();
    end
endmodule